// File: doc/BRIEF.md
# Isolated Memory Region Access Guard

This block screens memory requests against a small, parameterised table of protected address regions. Each region carries an inclusive page range, kept at 256-byte granularity, and two 32-bit permission masks: one for reads and one for writes. A request carries a 32-bit address, a direction flag and a 5-bit agent number. The agent number picks one bit of the mask for the request's direction in every region that covers the address.

Regions may overlap. A request is granted only when every region that covers it allows it. A request that no region covers is granted. The grant is combinational. A denied, valid request produces a one-clock violation pulse on the following cycle. That pulse is meant to drive a system reset request directly, so software plays no part in handling a violation.

Each region is programmed through four 32-bit configuration words. A sticky lock bit in a region's low-bound word freezes all four of that region's words until reset.

Top module: `iso_region_guard`

## Requirements
- R1: Configuration word offset = region × 16 + word × 4, and address bits [1:0] are ignored. Word 0 is the low bound: page in bits [23:0], lock in bit 31. Word 1 is the high bound: page in bits [23:0]. Word 2 is the read mask and word 3 is the write mask, each 32 bits wide. Every word reads back what was stored there.
- R2: Bit 30 of word 0 always reads 0 and ignores writes. Bits [29:24] of word 0 and bits [31:24] of word 1 behave the same way.
- R3: Writing word 0 with bit 31 set locks that region. After that, writes to any of its four words are ignored, and other regions stay writable.
- R4: A set lock bit cannot be cleared by any write. Only reset clears it.
- R5: A region covers a request when low ≤ address[31:8] ≤ high. Both ends are inclusive.
- R6: A region whose low and high pages are both zero covers nothing.
- R7: In a covering region, the request is allowed when bit `agent` of that region's mask is 1. The read mask is used when the write flag is 0, and the write mask is used when it is 1.
- R8: With overlapping regions, the grant is 1 only when every covering region allows the request.
- R9: A request that no region covers is granted.
- R10: The grant follows the request inputs in the same cycle. The violation output is 1 for exactly the cycle after each clock edge that sees a valid, denied request, and stays 0 when the valid flag is low.
- R11: After reset, every configuration word reads 0, no region is locked, and the violation output is 0.
- R12: A read mask of 0xBFFFFFFF admits every agent except agent 30. A write mask of 0xFFFFFFFF admits every agent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | $clog2(N_REGIONS*16) | Configuration byte offset |
| cfg_wdata | input | 32 | Configuration write data |
| cfg_rdata | output | 32 | Configuration read data, combinational on cfg_addr |
| req_valid | input | 1 | A memory request is present |
| req_addr | input | 32 | Request byte address |
| req_write | input | 1 | 1 for a write, 0 for a read |
| req_agent | input | 5 | Requesting agent number |
| req_grant | output | 1 | Combinational grant decision |
| viol_pulse | output | 1 | Registered violation, drives the system reset request |

## Verification
Configuration read data and the grant are combinational. The bench samples each of them one time unit after it drives the inputs on a falling edge, within the same cycle. A configuration write lands on the next rising edge, so its effect is read back at the falling edge that follows. The violation pulse passes through one register. For each request, the bench checks it at the first falling edge after the rising edge that captured the request. It then clears or changes the request so that the width of the pulse is checked one cycle later.

// File: rtl/iso_region_pkg.sv
package iso_region_pkg;
    localparam int REQ_AW     = 32;
    localparam int PAGE_SHIFT = 8;
    localparam int PAGE_W     = REQ_AW - PAGE_SHIFT;
    localparam int WORD_W     = 32;
    localparam int AGENT_W    = 5;
    localparam int LOCK_BIT   = 31;

    typedef enum logic [1:0] {
        W_LOW   = 2'd0,
        W_HIGH  = 2'd1,
        W_RMASK = 2'd2,
        W_WMASK = 2'd3
    } word_sel_e;

    typedef struct packed {
        logic              lock;
        logic [PAGE_W-1:0] lo;
        logic [PAGE_W-1:0] hi;
        logic [WORD_W-1:0] rmask;
        logic [WORD_W-1:0] wmask;
    } region_t;
endpackage

// File: rtl/iso_region_slot.sv
module iso_region_slot
    import iso_region_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  logic [1:0]          wr_sel,
    input  logic [WORD_W-1:0]   wr_data,
    input  logic [1:0]          rd_sel,
    output logic [WORD_W-1:0]   rd_data,
    input  logic [PAGE_W-1:0]   req_page,
    input  logic                req_write,
    input  logic [AGENT_W-1:0]  req_agent,
    output logic                allow
);
    region_t slot_d, slot_q;
    logic    in_use, hit, perm;

    always_comb begin
        slot_d = slot_q;
        if (wr_en && !slot_q.lock) begin
            case (word_sel_e'(wr_sel))
                W_LOW: begin
                    slot_d.lock = wr_data[LOCK_BIT];
                    slot_d.lo   = wr_data[PAGE_W-1:0];
                end
                W_HIGH:  slot_d.hi    = wr_data[PAGE_W-1:0];
                W_RMASK: slot_d.rmask = wr_data;
                W_WMASK: slot_d.wmask = wr_data;
                default: slot_d = slot_q;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) slot_q <= '0;
        else        slot_q <= slot_d;
    end

    always_comb begin
        rd_data = '0;
        case (word_sel_e'(rd_sel))
            W_LOW: begin
                rd_data[LOCK_BIT]   = slot_q.lock;
                rd_data[PAGE_W-1:0] = slot_q.lo;
            end
            W_HIGH:  rd_data[PAGE_W-1:0] = slot_q.hi;
            W_RMASK: rd_data = slot_q.rmask;
            W_WMASK: rd_data = slot_q.wmask;
            default: rd_data = '0;
        endcase
    end

    assign in_use = (slot_q.lo != '0) || (slot_q.hi != '0);
    assign hit    = in_use && (req_page >= slot_q.lo) && (req_page <= slot_q.hi);
    assign perm   = req_write ? slot_q.wmask[req_agent] : slot_q.rmask[req_agent];
    assign allow  = !hit || perm;

    assert_lock_freeze_R3: assert property (@(posedge clk) disable iff (!rst_n)
        slot_q.lock |=> (slot_q == $past(slot_q)));

    assert_lock_source_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(slot_q.lock) |-> $past(wr_en && wr_sel == 2'd0 && wr_data[LOCK_BIT]));

    assert_unused_open_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (slot_q.lo == '0 && slot_q.hi == '0) |-> allow);
endmodule

// File: rtl/iso_region_verdict.sv
module iso_region_verdict #(
    parameter int N_REGIONS = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [N_REGIONS-1:0] allow_vec,
    input  logic                 req_valid,
    output logic                 grant,
    output logic                 viol
);
    typedef struct packed {
        logic viol;
    } verdict_t;

    verdict_t v_d, v_q;

    always_comb begin
        grant    = &allow_vec;
        v_d.viol = req_valid && !grant;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) v_q <= '0;
        else        v_q <= v_d;
    end

    assign viol = v_q.viol;

    assert_deny_pulses_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !grant) |=> viol);

    assert_pulse_has_cause_R10: assert property (@(posedge clk) disable iff (!rst_n)
        viol |-> $past(req_valid && !grant));

    assert_any_veto_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (allow_vec != {N_REGIONS{1'b1}}) |-> !grant);
endmodule

// File: rtl/iso_region_guard.sv
module iso_region_guard
    import iso_region_pkg::*;
#(
    parameter int N_REGIONS = 8
) (
    input  logic                               clk,
    input  logic                               rst_n,
    input  logic                               cfg_we,
    input  logic [$clog2(N_REGIONS*16)-1:0]    cfg_addr,
    input  logic [31:0]                        cfg_wdata,
    output logic [31:0]                        cfg_rdata,
    input  logic                               req_valid,
    input  logic [31:0]                        req_addr,
    input  logic                               req_write,
    input  logic [4:0]                         req_agent,
    output logic                               req_grant,
    output logic                               viol_pulse
);
    localparam int CFG_AW = $clog2(N_REGIONS * 16);
    localparam int RIDX_W = CFG_AW - 4;

    logic [RIDX_W-1:0]    ridx;
    logic [1:0]           wsel;
    logic [WORD_W-1:0]    rd_arr [N_REGIONS];
    logic [N_REGIONS-1:0] allow_vec;
    logic [PAGE_W-1:0]    req_page;
    logic                 unused_low_bits;

    assign ridx     = cfg_addr[CFG_AW-1:4];
    assign wsel     = cfg_addr[3:2];
    assign req_page = req_addr[REQ_AW-1:PAGE_SHIFT];
    assign unused_low_bits = ^{cfg_addr[1:0], req_addr[PAGE_SHIFT-1:0]};

    for (genvar g = 0; g < N_REGIONS; g++) begin : g_slot
        iso_region_slot u_slot (
            .clk       (clk),
            .rst_n     (rst_n),
            .wr_en     (cfg_we && (int'(ridx) == g)),
            .wr_sel    (wsel),
            .wr_data   (cfg_wdata),
            .rd_sel    (wsel),
            .rd_data   (rd_arr[g]),
            .req_page  (req_page),
            .req_write (req_write),
            .req_agent (req_agent),
            .allow     (allow_vec[g])
        );
    end

    always_comb begin
        cfg_rdata = '0;
        if (int'(ridx) < N_REGIONS) cfg_rdata = rd_arr[ridx];
    end

    iso_region_verdict #(.N_REGIONS(N_REGIONS)) u_verdict (
        .clk       (clk),
        .rst_n     (rst_n),
        .allow_vec (allow_vec),
        .req_valid (req_valid),
        .grant     (req_grant),
        .viol      (viol_pulse)
    );

    assert_rsvd_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (wsel == 2'd0) |-> (cfg_rdata[30:PAGE_W] == '0));
endmodule

// File: tb/sim_iso_region_guard.sv
module sim_iso_region_guard;
    localparam int CLK_PERIOD = 10;
    localparam int NR = 8;
    localparam int CAW = $clog2(NR * 16);

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            cfg_we = 1'b0;
    logic [CAW-1:0]  cfg_addr = '0;
    logic [31:0]     cfg_wdata = '0;
    logic [31:0]     cfg_rdata;
    logic            req_valid = 1'b0;
    logic [31:0]     req_addr = '0;
    logic            req_write = 1'b0;
    logic [4:0]      req_agent = '0;
    logic            req_grant;
    logic            viol_pulse;

    int n_chk = 0;
    int n_fail = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    iso_region_guard #(.N_REGIONS(NR)) u0 (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .req_valid(req_valid),
        .req_addr(req_addr), .req_write(req_write), .req_agent(req_agent),
        .req_grant(req_grant), .viol_pulse(viol_pulse)
    );

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [CAW-1:0] off(int r, int w);
        return CAW'(r * 16 + w * 4);
    endfunction

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        req_valid = 1'b0;
        cfg_we = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic wr(int r, int w, logic [31:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = off(r, w); cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic rd_chk(string tag, int r, int w, logic [31:0] exp);
        cfg_addr = off(r, w);
        #1;
        chk(tag, cfg_rdata, exp);
    endtask

    task automatic probe(string tag, logic [23:0] page, logic wrt, logic [4:0] ag, logic exp_g);
        @(negedge clk);
        req_valid = 1'b1; req_addr = {page, 8'h00}; req_write = wrt; req_agent = ag;
        #1;
        chk({tag, " grant"}, 32'(req_grant), 32'(exp_g));
        @(negedge clk);
        chk({tag, " viol"}, 32'(viol_pulse), 32'(!exp_g));
        req_valid = 1'b0;
        @(negedge clk);
        chk({tag, " viol width R10"}, 32'(viol_pulse), 32'h0);
    endtask

    task automatic t_reset();
        for (int r = 0; r < NR; r++)
            for (int w = 0; w < 4; w++)
                rd_chk("R11 reset word", r, w, 32'h0);
        chk("R11 reset viol", 32'(viol_pulse), 32'h0);
        probe("R9 empty table", 24'h000123, 1'b0, 5'd3, 1'b1);
    endtask

    task automatic t_regmap();
        wr(2, 1, 32'hFFFF_FFFF);
        wr(2, 0, 32'h7FFF_FFFF);
        wr(2, 2, 32'h1234_5678);
        wr(3, 3, 32'hCAFE_F00D);
        @(negedge clk);
        rd_chk("R2 high upper bits zero", 2, 1, 32'h00FF_FFFF);
        rd_chk("R2 low bit30 zero, R3 not locked", 2, 0, 32'h00FF_FFFF);
        rd_chk("R1 read mask", 2, 2, 32'h1234_5678);
        rd_chk("R1 region 3 write mask", 3, 3, 32'hCAFE_F00D);
        rd_chk("R1 no alias into region 2", 2, 3, 32'h0);
        cfg_addr = off(2, 2) | CAW'(3);
        #1;
        chk("R1 low addr bits ignored", cfg_rdata, 32'h1234_5678);
        wr(2, 0, 32'h0); wr(2, 1, 32'h0); wr(2, 2, 32'h0); wr(3, 3, 32'h0);
        @(negedge clk);
        rd_chk("R3 region 2 still writable", 2, 0, 32'h0);
    endtask

    task automatic t_match();
        wr(0, 0, 32'h100); wr(0, 1, 32'h1FF);
        wr(0, 2, 32'h0);   wr(0, 3, 32'hFFFF_FFFF);
        probe("R5 low edge inclusive", 24'h000100, 1'b0, 5'd0, 1'b0);
        probe("R5 high edge inclusive", 24'h0001FF, 1'b0, 5'd0, 1'b0);
        probe("R5 above high", 24'h000200, 1'b0, 5'd0, 1'b1);
        probe("R5 below low", 24'h0000FF, 1'b0, 5'd0, 1'b1);
        probe("R7 write uses write mask", 24'h000150, 1'b1, 5'd0, 1'b1);
        wr(0, 2, 32'h0000_0020);
        probe("R7 agent 5 read allowed", 24'h000150, 1'b0, 5'd5, 1'b1);
        probe("R7 agent 6 read denied", 24'h000150, 1'b0, 5'd6, 1'b0);
    endtask

    task automatic t_viol();
        @(negedge clk);
        req_valid = 1'b0; req_addr = 32'h0001_5000; req_write = 1'b0; req_agent = 5'd6;
        @(negedge clk);
        chk("R10 no pulse without valid", 32'(viol_pulse), 32'h0);
        req_valid = 1'b1;
        @(negedge clk);
        chk("R10 first denied cycle", 32'(viol_pulse), 32'h1);
        @(negedge clk);
        chk("R10 second denied cycle", 32'(viol_pulse), 32'h1);
        req_valid = 1'b0;
        @(negedge clk);
        chk("R10 pulse ends", 32'(viol_pulse), 32'h0);
    endtask

    task automatic t_overlap();
        wr(1, 0, 32'h180); wr(1, 1, 32'h2FF);
        wr(1, 2, 32'hBFFF_FFFF); wr(1, 3, 32'hFFFF_FFFF);
        probe("R8 both regions allow", 24'h000190, 1'b0, 5'd5, 1'b1);
        probe("R8 one region vetoes", 24'h000190, 1'b0, 5'd7, 1'b0);
        probe("R8 only wide region covers", 24'h000250, 1'b0, 5'd7, 1'b1);
        probe("R12 read-all excludes agent 30", 24'h000250, 1'b0, 5'd30, 1'b0);
        probe("R12 write-all admits agent 30", 24'h000250, 1'b1, 5'd30, 1'b1);
        probe("R12 read-all admits agent 31", 24'h000250, 1'b0, 5'd31, 1'b1);
    endtask

    task automatic t_unused();
        probe("R6 zero region at page 0", 24'h000000, 1'b0, 5'd0, 1'b1);
        wr(4, 1, 32'h1);
        probe("R5 page 0 covered when high=1", 24'h000000, 1'b0, 5'd0, 1'b0);
        wr(4, 1, 32'h0);
        probe("R6 back to unused", 24'h000000, 1'b0, 5'd0, 1'b1);
    endtask

    task automatic t_lock();
        wr(5, 1, 32'h4FF); wr(5, 2, 32'h0); wr(5, 3, 32'h0);
        wr(5, 0, 32'h8000_0400);
        @(negedge clk);
        rd_chk("R3 lock reads back", 5, 0, 32'h8000_0400);
        wr(5, 0, 32'h0000_0000);
        wr(5, 1, 32'h0000_0000);
        wr(5, 2, 32'hFFFF_FFFF);
        wr(5, 3, 32'hFFFF_FFFF);
        wr(6, 2, 32'h0000_00AA);
        @(negedge clk);
        rd_chk("R4 lock survives clear write", 5, 0, 32'h8000_0400);
        rd_chk("R3 high frozen", 5, 1, 32'h0000_04FF);
        rd_chk("R3 read mask frozen", 5, 2, 32'h0);
        rd_chk("R3 write mask frozen", 5, 3, 32'h0);
        rd_chk("R3 neighbour writable", 6, 2, 32'h0000_00AA);
        probe("R3 locked region still enforces", 24'h000400, 1'b1, 5'd1, 1'b0);
        do_reset();
        @(negedge clk);
        rd_chk("R4 reset clears lock", 5, 0, 32'h0);
        rd_chk("R11 reset clears mask", 6, 2, 32'h0);
        wr(5, 2, 32'h0000_0001);
        @(negedge clk);
        rd_chk("R4 writable after reset", 5, 2, 32'h0000_0001);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired: actual=running expected=done");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        do_reset();
        @(negedge clk);
        t_reset();
        t_regmap();
        t_match();
        t_viol();
        t_overlap();
        t_unused();
        t_lock();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule